// File: doc/BRIEF.md
# CPU Register File with Program Counter and Stack Pointer

This block holds the sixteen 16-bit registers of a small orthogonal RISC core. Any instruction may name any register, so it offers two combinational read ports and one general write port. Three of the entries have fixed roles. Entry 0 is the program counter, entry 1 is the stack pointer and entry 2 is the status word. The block spans a flat 64 KB byte address space with no paging.

Beside the general write port there are three dedicated paths. A PC-advance strobe adds the length of the current instruction to the program counter. That length is 2, 4 or 6 bytes. Push and pop strobes adjust the stack pointer and also supply the memory address the stack access must use. A flag-load path lets the ALU refresh the low flag bits of the status word. The program counter and the stack pointer are kept even at all times.

The decoder, the ALU, the memory bus and interrupt sequencing all sit outside this block. It only supplies aligned register values and stack addresses.

Top module: `cpu_regfile`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, clears every register to zero. In the same edge it loads the program counter with `resetVector` with bit 0 cleared.
- R2: Both read ports are combinational. They return the current contents of any register, including program counter, stack pointer and status word. `pcOut`, `spOut` and `statusOut` mirror entries 0, 1 and 2.
- R3: With `wrEn` high, `wrData` is stored into entry `wrAddr` on the rising edge. A write to entry 0 or entry 1 stores the value with bit 0 forced to zero. Every other entry stores the full value.
- R4: With `pcAdvance` high and `advLen` equal to 2, 4 or 6, the program counter increases by `advLen` on the rising edge.
- R5: With `pcAdvance` high and any other `advLen` value, the program counter increases by 2. In that same cycle `lenError` is high, combinationally. `lenError` is low whenever `pcAdvance` is low or the length is legal.
- R6: In a push cycle, `stackAddr` equals the stack pointer minus 2. On the following edge, the stack pointer becomes that value.
- R7: In a pop cycle without a push, `stackAddr` equals the current stack pointer. On the following edge, the stack pointer increases by 2.
- R8: When push and pop are requested in the same cycle, the push takes effect and the pop is ignored.
- R9: A general write to entry 0 overrides a PC advance in the same cycle. A general write to entry 1 overrides a push or pop in the same cycle. In both cases the written value, with bit 0 cleared, is stored.
- R10: With `flagWrEn` high, the low `FLAG_W` bits of the status word are loaded from `flagIn` and its upper bits are kept. A general write to entry 2 in the same cycle takes priority over the flag load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| resetVector | input | DATA_W | Program counter value loaded at reset (bit 0 ignored) |
| rdAddrA | input | ADDR_W | Read port A register index |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | ADDR_W | Read port B register index |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | General write enable |
| wrAddr | input | ADDR_W | General write register index |
| wrData | input | DATA_W | General write data |
| pcAdvance | input | 1 | Advance the program counter by the instruction length |
| advLen | input | 3 | Instruction length in bytes (2, 4 or 6 are legal) |
| pushReq | input | 1 | Stack push: pre-decrement stack pointer |
| popReq | input | 1 | Stack pop: post-increment stack pointer |
| stackAddr | output | DATA_W | Memory address for the current stack access |
| flagWrEn | input | 1 | Load status flag bits from `flagIn` |
| flagIn | input | FLAG_W | New flag bits from the ALU |
| pcOut | output | DATA_W | Current program counter |
| spOut | output | DATA_W | Current stack pointer |
| statusOut | output | DATA_W | Current status word |
| lenError | output | 1 | Illegal advance length seen this cycle |

## Verification
The bench builds the block with its defaults: 16-bit words, sixteen entries and four flag bits. With these settings the three special entries coexist with thirteen plain ones, so a write to entry 7 shows that a plain register keeps bit 0. A status word of 16 bits against four flag bits shows that a flag load leaves the upper twelve bits alone. A table walk of mixed legal and illegal lengths exercises the even alignment and the length fallback on the real program counter width. Directed cycles then force every priority clash between the general port and the special paths.

// File: rtl/regfile_pkg.sv
`timescale 1ns/1ps
package regfile_pkg;
  localparam int LEN_W = 3;

  typedef struct packed {
    logic             genWe;
    logic             pcStep;
    logic [LEN_W-1:0] stepBytes;
    logic             spDec;
    logic             spInc;
    logic             flagLoad;
    logic             pushAddr;
  } rfCtrl_t;
endpackage

// File: rtl/regfile_ctrl.sv
`timescale 1ns/1ps
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int PC_IDX   = 0,
  parameter int SP_IDX   = 1,
  parameter int SR_IDX   = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              pcAdvance,
  input  logic [LEN_W-1:0]  advLen,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              flagWrEn,
  output rfCtrl_t           ctrl,
  output logic              lenError
);
  logic legalLen;
  logic wrPc;
  logic wrSp;
  logic wrSr;

  always_comb begin
    legalLen = (advLen == LEN_W'(2)) || (advLen == LEN_W'(4)) || (advLen == LEN_W'(6));
    wrPc     = wrEn && (wrAddr == ADDR_W'(PC_IDX));
    wrSp     = wrEn && (wrAddr == ADDR_W'(SP_IDX));
    wrSr     = wrEn && (wrAddr == ADDR_W'(SR_IDX));

    ctrl.genWe     = wrEn;
    ctrl.pcStep    = pcAdvance && !wrPc;
    ctrl.stepBytes = legalLen ? advLen : LEN_W'(2);
    ctrl.spDec     = pushReq && !wrSp;
    ctrl.spInc     = popReq && !pushReq && !wrSp;
    ctrl.flagLoad  = flagWrEn && !wrSr;
    ctrl.pushAddr  = pushReq;

    lenError = pcAdvance && !legalLen;
  end
endmodule

// File: rtl/regfile_datapath.sv
`timescale 1ns/1ps
module regfile_datapath
  import regfile_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int FLAG_W   = 4,
  parameter int PC_IDX   = 0,
  parameter int SP_IDX   = 1,
  parameter int SR_IDX   = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] resetVector,
  input  rfCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagIn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut
);
  localparam logic [DATA_W-1:0] EVEN_MASK = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] stepExt;

  assign stepExt = {{(DATA_W-LEN_W){1'b0}}, ctrl.stepBytes};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit     = ctrl.genWe && (wrAddr == ADDR_W'(i));
    assign regs[i] = q;

    if (i == PC_IDX) begin : g_pc
      always_ff @(posedge clk) begin
        if (rst)              q <= resetVector & EVEN_MASK;
        else if (hit)         q <= wrData & EVEN_MASK;
        else if (ctrl.pcStep) q <= (q + stepExt) & EVEN_MASK;
      end
    end else if (i == SP_IDX) begin : g_sp
      always_ff @(posedge clk) begin
        if (rst)              q <= '0;
        else if (hit)         q <= wrData & EVEN_MASK;
        else if (ctrl.spDec)  q <= (q - WORD_STEP) & EVEN_MASK;
        else if (ctrl.spInc)  q <= (q + WORD_STEP) & EVEN_MASK;
      end
    end else if (i == SR_IDX) begin : g_sr
      always_ff @(posedge clk) begin
        if (rst)                q <= '0;
        else if (hit)           q <= wrData;
        else if (ctrl.flagLoad) q <= {q[DATA_W-1:FLAG_W], flagIn};
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wrData;
      end
    end
  end

  always_comb begin
    rdDataA   = regs[rdAddrA];
    rdDataB   = regs[rdAddrB];
    pcOut     = regs[PC_IDX];
    spOut     = regs[SP_IDX];
    statusOut = regs[SR_IDX];
    stackAddr = ctrl.pushAddr ? (regs[SP_IDX] - WORD_STEP) : regs[SP_IDX];
  end
endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/1ps
module cpu_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int FLAG_W   = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] resetVector,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcAdvance,
  input  logic [2:0]        advLen,
  input  logic              pushReq,
  input  logic              popReq,
  output logic [DATA_W-1:0] stackAddr,
  input  logic              flagWrEn,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              lenError
);
  rfCtrl_t ctrl;

  regfile_ctrl #(
    .NUM_REGS(NUM_REGS)
  ) ctrl_i (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .pcAdvance(pcAdvance),
    .advLen   (advLen),
    .pushReq  (pushReq),
    .popReq   (popReq),
    .flagWrEn (flagWrEn),
    .ctrl     (ctrl),
    .lenError (lenError)
  );

  regfile_datapath #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .FLAG_W  (FLAG_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .resetVector(resetVector),
    .ctrl       (ctrl),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .flagIn     (flagIn),
    .rdAddrA    (rdAddrA),
    .rdAddrB    (rdAddrB),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .stackAddr  (stackAddr),
    .pcOut      (pcOut),
    .spOut      (spOut),
    .statusOut  (statusOut)
  );
endmodule

// File: rtl/cpu_regfile_chk.sv
`timescale 1ns/1ps
module cpu_regfile_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int FLAG_W   = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              pcAdvance,
  input logic [2:0]        advLen,
  input logic              pushReq,
  input logic              popReq,
  input logic [DATA_W-1:0] stackAddr,
  input logic              flagWrEn,
  input logic [FLAG_W-1:0] flagIn,
  input logic [DATA_W-1:0] pcOut,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] statusOut,
  input logic              lenError
);
  logic legal;
  logic [DATA_W-1:0] expStep;
  logic wPc, wSp, wSr;

  assign legal   = (advLen == 3'd2) || (advLen == 3'd4) || (advLen == 3'd6);
  assign expStep = legal ? DATA_W'(advLen) : DATA_W'(2);
  assign wPc     = wrEn && (wrAddr == ADDR_W'(0));
  assign wSp     = wrEn && (wrAddr == ADDR_W'(1));
  assign wSr     = wrEn && (wrAddr == ADDR_W'(2));

  p_pc_even_r3: assert property (@(posedge clk) disable iff (rst) pcOut[0] == 1'b0);
  p_sp_even_r3: assert property (@(posedge clk) disable iff (rst) spOut[0] == 1'b0);

  p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
    (pcAdvance && !wPc) |=> (pcOut == $past(pcOut + expStep)));

  p_len_err_r5: assert property (@(posedge clk) disable iff (rst)
    lenError == (pcAdvance && !legal));

  p_push_addr_r6: assert property (@(posedge clk) disable iff (rst)
    pushReq |-> (stackAddr == spOut - DATA_W'(2)));

  p_push_r8: assert property (@(posedge clk) disable iff (rst)
    (pushReq && !wSp) |=> (spOut == $past(spOut) - DATA_W'(2)));

  p_pop_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (popReq && !pushReq) |-> (stackAddr == spOut));

  p_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (popReq && !pushReq && !wSp) |=> (spOut == $past(spOut) + DATA_W'(2)));

  p_wr_pc_prio_r9: assert property (@(posedge clk) disable iff (rst)
    wPc |=> (pcOut == ($past(wrData) & ~DATA_W'(1))));

  p_wr_sp_prio_r9: assert property (@(posedge clk) disable iff (rst)
    wSp |=> (spOut == ($past(wrData) & ~DATA_W'(1))));

  p_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (flagWrEn && !wSr) |=> (statusOut == {$past(statusOut[DATA_W-1:FLAG_W]), $past(flagIn)}));
endmodule

bind cpu_regfile cpu_regfile_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FLAG_W(FLAG_W)
) chk_i (.*);

// File: tb/cpu_regfile_tb_top.sv
`timescale 1ns/1ps
module cpu_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] resetVector;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [15:0] rdDataA, rdDataB, wrData, stackAddr, pcOut, spOut, statusOut;
  logic        wrEn, pcAdvance, pushReq, popReq, flagWrEn, lenError;
  logic [2:0]  advLen;
  logic [3:0]  flagIn;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_regfile dut_i (.*);

  // {advLen, expected lenError, expected pc after the edge}
  localparam logic [19:0] ADV_TBL [8] = '{
    {3'd2, 1'b0, 16'h1002},
    {3'd4, 1'b0, 16'h1006},
    {3'd6, 1'b0, 16'h100C},
    {3'd0, 1'b1, 16'h100E},
    {3'd6, 1'b0, 16'h1014},
    {3'd7, 1'b1, 16'h1016},
    {3'd4, 1'b0, 16'h101A},
    {3'd3, 1'b1, 16'h101C}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrAddr = 0; wrData = 0; pcAdvance = 0; advLen = 0;
    pushReq = 0; popReq = 0; flagWrEn = 0; flagIn = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic doReset(input logic [15:0] vec);
    idle();
    rst = 1; resetVector = vec;
    tick(); tick();
    rst = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rdAddrA = 0; rdAddrB = 0;
    doReset(16'h1001);
    // R1 reset state
    check("R1 pc reset", pcOut, 16'h1000);
    check("R1 sp reset", spOut, 16'h0000);
    rdAddrA = 4'd9; rdAddrB = 4'd2; #1;
    check("R1 r9 reset", rdDataA, 16'h0000);
    check("R1 status reset", rdDataB, 16'h0000);

    // R4 / R5 table walk
    for (int i = 0; i < 8; i++) begin
      pcAdvance = 1; advLen = ADV_TBL[i][19:17]; #1;
      check("R5 lenError", {15'd0, lenError}, {15'd0, ADV_TBL[i][16]});
      tick();
      check("R4 pc advance", pcOut, ADV_TBL[i][15:0]);
    end
    #1;
    check("R5 lenError idle", {15'd0, lenError}, 16'd0);

    // R3 writes, R2 reads
    wrEn = 1; wrAddr = 4'd7; wrData = 16'hABCD; tick();
    rdAddrA = 4'd7; rdAddrB = 4'd7; #1;
    check("R3 r7 portA", rdDataA, 16'hABCD);
    check("R2 r7 portB", rdDataB, 16'hABCD);
    wrEn = 1; wrAddr = 4'd1; wrData = 16'h2001; tick();
    check("R3 sp even write", spOut, 16'h2000);
    rdAddrA = 4'd1; rdAddrB = 4'd0; #1;
    check("R2 read sp", rdDataA, 16'h2000);
    check("R2 read pc", rdDataB, 16'h101C);

    // R6 push
    pushReq = 1; #1;
    check("R6 push addr", stackAddr, 16'h1FFE);
    tick();
    check("R6 sp after push", spOut, 16'h1FFE);

    // R7 pop
    popReq = 1; #1;
    check("R7 pop addr", stackAddr, 16'h1FFE);
    tick();
    check("R7 sp after pop", spOut, 16'h2000);

    // R8 push and pop together
    pushReq = 1; popReq = 1; #1;
    check("R8 both addr", stackAddr, 16'h1FFE);
    tick();
    check("R8 push wins", spOut, 16'h1FFE);

    // R9 priorities
    wrEn = 1; wrAddr = 4'd1; wrData = 16'h3001; pushReq = 1; tick();
    check("R9 sp write over push", spOut, 16'h3000);
    wrEn = 1; wrAddr = 4'd0; wrData = 16'h4003; pcAdvance = 1; advLen = 3'd4; tick();
    check("R9 pc write over advance", pcOut, 16'h4002);

    // R10 flags
    wrEn = 1; wrAddr = 4'd2; wrData = 16'hF0A0; tick();
    flagWrEn = 1; flagIn = 4'h5; tick();
    check("R10 flag load", statusOut, 16'hF0A5);
    wrEn = 1; wrAddr = 4'd2; wrData = 16'h1234; flagWrEn = 1; flagIn = 4'hF; tick();
    check("R10 write over flags", statusOut, 16'h1234);

    // R1 reset again
    doReset(16'h8006);
    rdAddrA = 4'd7; #1;
    check("R1 r7 cleared", rdDataA, 16'h0000);
    check("R1 pc new vector", pcOut, 16'h8006);
    check("R1 sp cleared", spOut, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule